// File: doc/BRIEF.md
# Stretchable CPU Clock with Bank Address Hold

This block derives the processor bus clock (PHI2) from a faster oscillator and lets a slow peripheral pause the processor by keeping PHI2 in its high phase. The peripheral requests a pause on an active-low stop input. That input crosses into the oscillator domain through a chain of synchronizing flops. The request takes effect only in the first oscillator cycle of a high phase. From then on PHI2 stays high for as long as the request lasts.

The processor drives the upper address bits (the bank) on the data bus only while PHI2 is low. The block follows the data bus throughout the low phase. Its last sample is taken on the oscillator edge that raises PHI2, and it holds that value for the whole high phase, including any pause. A ready-style stall would let PHI2 keep toggling, so the bank register would reload with stray bus data during the stall. Stretching the high phase keeps the register closed for the entire wait.

The synchronizer starts in the "stop requested" state. A peripheral that is still booting and holds the request asserted through reset therefore keeps the processor frozen from the first PHI2 rising edge.

Top module: `phi2_stretch`

## Requirements
- R1: While rst_ni is low, phi2_o is 0 and bank_o is all zeros.
- R2: With stop_ni held high, phi2_o is low for LOW_CYC oscillator cycles, then high for HIGH_CYC cycles, and repeats. The defaults of 1 and 1 give the oscillator divided by two.
- R3: stop_ni reaches the phase logic only after SYNC_STAGES oscillator flops. The synchronized request is acted on only in the first oscillator cycle of a high phase. A request that appears later in the same high phase has no effect on that phase.
- R4: phi2_o never shows a low phase shorter than LOW_CYC cycles or a high phase shorter than HIGH_CYC cycles.
- R5: A request honoured in the first high cycle keeps phi2_o high, with the phase counter frozen, for as long as the synchronized request stays asserted. Once the request clears, the high phase runs its full HIGH_CYC cycles and is followed by a normal low phase of LOW_CYC cycles.
- R6: Reset leaves the synchronizer in the "stop requested" state. If stop_ni is held low across reset release, phi2_o rises after LOW_CYC cycles and then stays high, and no complete PHI2 cycle occurs.
- R7: On every oscillator edge at which phi2_o is low before the edge, bank_o loads data_i. The edge that raises phi2_o therefore supplies the bank value used for that access.
- R8: Throughout a high phase, including a stretched one, bank_o holds its value, and changes on data_i have no effect on it.
- R9: stop_ni is active low: 0 requests a stop and 1 lets PHI2 run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_ni | input | 1 | Stop request from the slow peripheral, active low, asynchronous |
| data_i | input | DATA_W | Processor data bus carrying the bank during PHI2 low |
| phi2_o | output | 1 | Stretchable processor clock |
| bank_o | output | DATA_W | Bank address held for the current access |

## Verification
A corrupted phase counter appears at phi2_o within one PHI2 period as a low or high run of the wrong length. A synchronizer in the wrong state shows up as a high phase that is stretched when it should not be, or one that is not stretched when it should be, within SYNC_STAGES plus one PHI2 period of the stop edge. A bank register that loads while PHI2 is high changes bank_o on the very next oscillator cycle, because data_i moves every cycle. The stall and reset cases make this visible even during long pauses.

// File: rtl/phi2_stretch_pkg.sv
package phi2_stretch_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/stop_sync.sv
module stop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_ni,
  output logic stop_req_o
);
  logic [STAGES-1:0] sync_q;

  // resets to "stop requested" so a booting peripheral holds the cpu
  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= ~stop_ni;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], ~stop_ni};
      end
    end
  endgenerate

  assign stop_req_o = sync_q[STAGES-1];
endmodule

// File: rtl/phi2_gen.sv
module phi2_gen
  import phi2_stretch_pkg::*;
#(
  parameter int unsigned LOW_CYC  = 1,
  parameter int unsigned HIGH_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_req_i,
  output logic phi2_o
);
  localparam int unsigned MAX_C = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int unsigned CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_LOW: begin
        if (cnt_q == LOW_LAST) begin
          phase_d = PH_HIGH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      PH_HIGH: begin
        // stall only in the first high cycle: no runt phases
        if (cnt_q == '0 && stop_req_i) begin
          cnt_d = '0;
        end else if (cnt_q == HIGH_LAST) begin
          phase_d = PH_LOW;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        phase_d = PH_LOW;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phi2_o = (phase_q == PH_HIGH);

  // R5
  hold_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi2_o && cnt_q == '0 && stop_req_i) |=> phi2_o);

  // R4
  low_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phi2_o && cnt_q != LOW_LAST) |=> !phi2_o);

  // R4
  high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phi2_o && cnt_q != HIGH_LAST) |=> phi2_o);
endmodule

// File: rtl/bank_hold.sv
module bank_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phi2_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] bank_o
);
  logic [DATA_W-1:0] bank_q;

  // open while phi2 low; last load is the edge that raises phi2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bank_q <= '0;
    else if (!phi2_i) bank_q <= data_i;
  end

  assign bank_o = bank_q;
endmodule

// File: rtl/phi2_stretch.sv
module phi2_stretch #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LOW_CYC     = 1,
  parameter int unsigned HIGH_CYC    = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              phi2_o,
  output logic [DATA_W-1:0] bank_o
);
  logic stop_req;

  stop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_ni    (stop_ni),
    .stop_req_o (stop_req)
  );

  phi2_gen #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_req_i (stop_req),
    .phi2_o     (phi2_o)
  );

  bank_hold #(.DATA_W(DATA_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phi2_i (phi2_o),
    .data_i (data_i),
    .bank_o (bank_o)
  );

  // R8
  bank_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(phi2_o) |-> $stable(bank_o));

  // R7
  bank_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(phi2_o)) |-> bank_o == $past(data_i));
endmodule

// File: tb/phi2_stretch_tb.sv
`timescale 1ns/1ps
module phi2_stretch_tb_top;
  localparam int DW = 8;
  localparam int LC = 2;
  localparam int HC = 3;
  localparam int SS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stop_n = 1'b1;
  logic [DW-1:0] data = 8'h5a;
  logic          phi2;
  logic [DW-1:0] bank;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phi2_stretch #(.DATA_W(DW), .LOW_CYC(LC), .HIGH_CYC(HC), .SYNC_STAGES(SS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n), .data_i(data),
    .phi2_o(phi2), .bank_o(bank)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // bus data moves every cycle so any stray load shows
  always @(negedge clk) data <= data + 8'd29;

  // reference behaviour from the requirements
  logic [SS-1:0] m_sync;
  logic          m_phi;
  int            m_cnt;
  logic [DW-1:0] m_bank;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= '1; m_phi <= 1'b0; m_cnt <= 0; m_bank <= '0;
    end else begin
      m_sync <= {m_sync[SS-2:0], ~stop_n};
      if (!m_phi) m_bank <= data;
      if (!m_phi) begin
        if (m_cnt == LC-1) begin m_phi <= 1'b1; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end else begin
        if (m_cnt == 0 && m_sync[SS-1]) m_cnt <= 0;
        else if (m_cnt == HC-1) begin m_phi <= 1'b0; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  // per-cycle comparison and runt tracking
  logic prev_phi;
  int   run_len;
  bit   seen_edge;
  always @(negedge clk) begin
    if (!rst_n) begin
      seen_edge = 1'b0; run_len = 0; prev_phi = 1'b0;
    end else if (cmp_en) begin
      chk(phi2 === m_phi, "R3/R5 phi2", phi2, m_phi);
      chk(bank === m_bank, "R7/R8 bank", bank, m_bank);
      if (phi2 == prev_phi) run_len++;
      else begin
        if (seen_edge)
          chk(run_len >= (prev_phi ? HC : LC), "R4 phase length", run_len, prev_phi ? HC : LC);
        seen_edge = 1'b1;
        run_len = 1;
        prev_phi = phi2;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    int highs;
    logic [DW-1:0] held;
    // R1: reset state with stop requested (booting peripheral)
    stop_n = 1'b0;
    cyc(4);
    chk(phi2 == 1'b0, "R1 phi2 in reset", phi2, 0);
    chk(bank == '0, "R1 bank in reset", bank, 0);
    cyc(1);
    chk(bank == '0, "R1 bank in reset later", bank, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    // R6: held stop across reset release, cpu frozen after first rise
    cyc(LC);
    chk(phi2 == 1'b1, "R6 first rise", phi2, 1);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (phi2) highs++;
    end
    chk(highs == 20, "R6 frozen high", highs, 20);
    // R8/R9: bank held through stall while data moves
    held = bank;
    cyc(6);
    chk(bank == held, "R8 bank during stall", bank, held);
    chk(phi2 == 1'b1, "R9 active-low stop keeps phi2 high", phi2, 1);
    stop_n = 1'b1;
    cyc(SS + HC + 2);
    // R2: free run, duty over whole periods
    highs = 0;
    for (int i = 0; i < 6 * (LC + HC); i++) begin
      cyc(1);
      if (phi2) highs++;
    end
    chk(highs == 6 * HC, "R2 free-run high count", highs, 6 * HC);
    // R3/R5: sweep stop pulse offset and length
    for (int off = 0; off < LC + HC; off++) begin
      for (int len = 1; len <= 9; len++) begin
        cyc(6 + off);
        stop_n = 1'b0;
        cyc(len);
        stop_n = 1'b1;
        cyc(12);
      end
    end
    // R1: reset again mid-run
    rst_n = 1'b0;
    cyc(2);
    chk(phi2 == 1'b0, "R1 phi2 after re-reset", phi2, 0);
    chk(bank == '0, "R1 bank after re-reset", bank, 0);
    rst_n = 1'b1;
    cyc(40);
    report();
  end
endmodule